// File: doc/BRIEF.md
# Cascaded Banked Interrupt Controller

This block gathers 32 interrupt sources into four banks of eight lines. Each bank resolves its own lines and passes a single request to an eight-input master stage. The master also takes one external chipset interrupt on its input 0. The master picks the highest-priority input that is not masked and not blocked. It raises a single interrupt request to the processor and reports the number of the winning source.

Software controls the block through a byte-wide write port. The port holds a mask per bank, a master mask and a two-byte trigger-mode register. Some expansion-bus lines can be switched from edge to level triggering; all other sources stay edge-triggered.

When the processor acknowledges a request, the winner is marked in service in both its bank and the master. That blocks the winner and everything of lower priority until software writes a specific end-of-interrupt command to the bank and then to the master.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, all four bank masks are 0xFF, the master mask and both trigger-mode bytes are 0x00, nothing is in service and `irq_o` is low.
- R2: An edge-triggered source latches a request on a rising input edge. The request stays pending after the input falls and is cleared only when that source is granted.
- R3: The trigger-mode bytes select level mode (bit = 1) for source s = n+7 of expansion line n. Byte 0 (address 5): bits 0..4 serve n = 3..7 and bits 5..7 serve n = 9..11. Byte 1 (address 6): bit 0 serves n = 12 and bits 1..2 serve n = 14..15. A level source requests only while its input is high. All other sources are edge-triggered.
- R4: A 1 in a bank mask (addresses 0..3 for banks 0..3) disables that line. A 1 in the master mask (address 4) disables that master input. A request latched while masked is kept and is presented once the mask bit is cleared.
- R5: Source s belongs to bank s>>3, line s&7. Banks 0, 1, 2 and 3 drive master inputs 1, 3, 4 and 5. Inputs 2, 6 and 7 never request. The lowest-numbered eligible line wins within a bank, and the lowest-numbered eligible master input wins overall. `vec_o` = bank*8 + line.
- R6: Master input 0 is the external chipset line, sampled as a level. When it wins, `ext_o` = 1 and `vec_o` = 0.
- R7: `ack_i` while `irq_o` is high grants the winner. It sets the in-service bit in the master and, for a bank source, in the bank. An in-service bit blocks its own position and all lower-priority positions, while higher-priority ones can still win.
- R8: A write of 0xE0|k clears in-service bit k. Writes to address 8+b go to bank b; writes to address 12 go to the master. Bytes whose upper five bits differ from 11100 are ignored. A bank source is served again only after both its bank EOI and its master EOI.
- R9: `ack_i` while `irq_o` is low has no effect.
- R10: An input sampled at a clock edge affects `irq_o`, `ext_o` and `vec_o` from that edge on, with one register stage of latency. A register write takes effect at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source lines |
| chip_irq_i | input | 1 | External chipset interrupt (master input 0) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Processor acknowledge, grants current winner |
| irq_o | output | 1 | Interrupt request to the processor |
| ext_o | output | 1 | Winner is the external chipset line |
| vec_o | output | 5 | Number of the winning source |

## Verification
A wrong in-service bit shows up one cycle after the grant or EOI that should have changed it. It either suppresses `irq_o` for a source that should be served or lets a lower-priority source through while a higher one is in service. A lost or stuck edge latch changes `irq_o` or `vec_o` in the cycle after the input edge, or after the mask is cleared. An error in the trigger-mode mapping appears when a level line drops and `irq_o` does not fall, or does fall for an edge line. Because the outputs follow the registered state directly, the bench model catches any of these on the first clock where the state diverges.

// File: rtl/casc_irq_pkg.sv
// Shared constants, types and helpers for the cascaded interrupt controller.
// Assumes eight lines per bank and an eight-input master stage.
package casc_irq_pkg;
    localparam int NBANK    = 4;
    localparam int NLINE    = 8;
    localparam int NSRC     = NBANK * NLINE;
    localparam int LW       = $clog2(NLINE);
    localparam int BW       = $clog2(NBANK);
    localparam int SW       = $clog2(NSRC);
    localparam int AW       = 4;
    localparam int EXP_BASE = 7;                 // expansion line n is source n+EXP_BASE
    localparam logic [4:0] EOI_HEAD = 5'b11100;  // upper bits of a specific EOI byte

    typedef logic [NLINE-1:0] line_vec_t;

    // Register addresses
    localparam logic [AW-1:0] ADR_MMASK = 4'd4;
    localparam logic [AW-1:0] ADR_TRIG0 = 4'd5;
    localparam logic [AW-1:0] ADR_TRIG1 = 4'd6;
    localparam logic [AW-1:0] ADR_MCMD  = 4'd12;
    localparam logic [1:0]    PAGE_BMASK = 2'b00;
    localparam logic [1:0]    PAGE_BCMD  = 2'b10;

    // Master input driven by each bank
    function automatic logic [LW-1:0] bank_to_master(input int b);
        case (b)
            0:       return LW'(1);
            1:       return LW'(3);
            2:       return LW'(4);
            default: return LW'(5);
        endcase
    endfunction

    // Positions strictly ahead of the highest-priority in-service bit
    function automatic line_vec_t open_below(input line_vec_t isr);
        line_vec_t r;
        logic blk;
        blk = 1'b0;
        for (int i = 0; i < NLINE; i++) begin
            blk  = blk | isr[i];
            r[i] = ~blk;
        end
        return r;
    endfunction

    // Index of the lowest set bit (0 when empty)
    function automatic logic [LW-1:0] lowest_idx(input line_vec_t v);
        logic [LW-1:0] idx;
        idx = '0;
        for (int i = NLINE - 1; i >= 0; i--) begin
            if (v[i]) idx = LW'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/casc_irq_regs.sv
// Register file and command decoder of the interrupt controller.
// Holds bank masks, master mask and the two trigger-mode bytes.
// Decodes specific EOI writes into per-bank and master clear strobes.
// Assumes single-cycle write strobes; there is no read path.
module casc_irq_regs
    import casc_irq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [AW-1:0]                 wr_addr_i,
    input  logic [7:0]                    wr_data_i,
    output logic [NBANK-1:0][NLINE-1:0]   bank_mask_o,
    output logic [NLINE-1:0]              mstr_mask_o,
    output logic [NSRC-1:0]               level_map_o,
    output logic [NBANK-1:0]              bank_eoi_o,
    output logic                          mstr_eoi_o,
    output logic [LW-1:0]                 eoi_line_o
);
    logic [7:0] trig_lo_q;
    logic [2:0] trig_hi_q;
    logic       is_eoi;

    // Register writes; bank masks start fully closed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_mask_o <= '1;
            mstr_mask_o <= '0;
            trig_lo_q   <= '0;
            trig_hi_q   <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i[AW-1:AW-2] == PAGE_BMASK)
                bank_mask_o[wr_addr_i[BW-1:0]] <= wr_data_i;
            else if (wr_addr_i == ADR_MMASK)
                mstr_mask_o <= wr_data_i;
            else if (wr_addr_i == ADR_TRIG0)
                trig_lo_q <= wr_data_i;
            else if (wr_addr_i == ADR_TRIG1)
                trig_hi_q <= wr_data_i[2:0];
        end
    end

    // Spread the trigger-mode bits onto their source numbers
    always_comb begin
        level_map_o = '0;
        for (int i = 0; i < 5; i++) level_map_o[EXP_BASE + 3 + i] = trig_lo_q[i];
        for (int i = 0; i < 3; i++) level_map_o[EXP_BASE + 9 + i] = trig_lo_q[5 + i];
        level_map_o[EXP_BASE + 12] = trig_hi_q[0];
        level_map_o[EXP_BASE + 14] = trig_hi_q[1];
        level_map_o[EXP_BASE + 15] = trig_hi_q[2];
    end

    // Specific EOI command decode
    assign is_eoi     = wr_en_i && (wr_data_i[7:3] == EOI_HEAD);
    assign eoi_line_o = wr_data_i[LW-1:0];
    assign mstr_eoi_o = is_eoi && (wr_addr_i == ADR_MCMD);

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bcmd
            assign bank_eoi_o[b] = is_eoi && (wr_addr_i[AW-1:AW-2] == PAGE_BCMD)
                                   && (wr_addr_i[BW-1:0] == BW'(b));
        end
    endgenerate
endmodule

// File: rtl/casc_irq_bank.sv
// One slave bank: samples eight lines, latches edges, and tracks in-service lines.
// Resolves the lowest eligible line. Level lines request from their sampled input.
// Edge latches are held at zero while a line is in level mode.
module casc_irq_bank
    import casc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  line_vec_t       src_i,
    input  line_vec_t       level_i,
    input  line_vec_t       mask_i,
    input  logic            grant_i,
    input  logic            eoi_i,
    input  logic [LW-1:0]   eoi_line_i,
    output logic            req_o,
    output logic [LW-1:0]   line_o,
    output line_vec_t       isr_o
);
    line_vec_t src_q, edge_q, pend, cand, gnt_vec, eoi_vec;

    assign pend    = (level_i & src_q) | (~level_i & edge_q);
    assign cand    = pend & ~mask_i & open_below(isr_o);
    assign req_o   = |cand;
    assign line_o  = lowest_idx(cand);
    assign gnt_vec = grant_i ? (line_vec_t'(1) << line_o) : '0;
    assign eoi_vec = eoi_i ? (line_vec_t'(1) << eoi_line_i) : '0;

    // Input sample and edge latch; a grant consumes the latched edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            edge_q <= '0;
        end else begin
            src_q  <= src_i;
            edge_q <= ~level_i & ((edge_q & ~gnt_vec) | (src_i & ~src_q));
        end
    end

    // In-service tracking: EOI clears, grant sets
    always_ff @(posedge clk) begin
        if (!rst_n) isr_o <= '0;
        else        isr_o <= (isr_o & ~eoi_vec) | gnt_vec;
    end
endmodule

// File: rtl/casc_irq_master.sv
// Master stage: resolves eight request inputs against its mask and in-service bits.
// Assumes its inputs are already registered upstream.
module casc_irq_master
    import casc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  line_vec_t       req_i,
    input  line_vec_t       mask_i,
    input  logic            grant_i,
    input  logic            eoi_i,
    input  logic [LW-1:0]   eoi_line_i,
    output logic            win_o,
    output logic [LW-1:0]   idx_o,
    output line_vec_t       isr_o
);
    line_vec_t cand, gnt_vec, eoi_vec;

    assign cand    = req_i & ~mask_i & open_below(isr_o);
    assign win_o   = |cand;
    assign idx_o   = lowest_idx(cand);
    assign gnt_vec = (grant_i && win_o) ? (line_vec_t'(1) << idx_o) : '0;
    assign eoi_vec = eoi_i ? (line_vec_t'(1) << eoi_line_i) : '0;

    // In-service tracking for master inputs
    always_ff @(posedge clk) begin
        if (!rst_n) isr_o <= '0;
        else        isr_o <= (isr_o & ~eoi_vec) | gnt_vec;
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
// Top of the cascaded interrupt controller: four banks on irregular master inputs,
// plus the external chipset line on master input 0.
// Outputs follow registered state combinationally.
// ack_i is honoured only while irq_o is high.
module casc_irq_ctrl
    import casc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      src_i,
    input  logic             chip_irq_i,
    input  logic             wr_en_i,
    input  logic [3:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             ext_o,
    output logic [4:0]       vec_o
);
    logic [NBANK-1:0][NLINE-1:0] bank_mask;
    logic [NLINE-1:0]            mstr_mask;
    logic [NSRC-1:0]             level_map;
    logic [NBANK-1:0]            bank_eoi;
    logic                        mstr_eoi;
    logic [LW-1:0]               eoi_line;
    logic [NBANK-1:0]            bank_req;
    logic [NBANK-1:0][LW-1:0]    bank_line;
    logic [NBANK-1:0][NLINE-1:0] bank_isr;
    logic [NBANK-1:0]            bank_gnt;
    line_vec_t                   m_req, m_isr;
    logic                        m_win;
    logic [LW-1:0]               m_idx;
    logic                        chip_q;
    logic                        grant_ok;
    logic                        hit;
    logic [BW-1:0]               win_bank;

    casc_irq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .bank_mask_o (bank_mask),
        .mstr_mask_o (mstr_mask),
        .level_map_o (level_map),
        .bank_eoi_o  (bank_eoi),
        .mstr_eoi_o  (mstr_eoi),
        .eoi_line_o  (eoi_line)
    );

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            casc_irq_bank u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_i      (src_i[b*NLINE +: NLINE]),
                .level_i    (level_map[b*NLINE +: NLINE]),
                .mask_i     (bank_mask[b]),
                .grant_i    (bank_gnt[b]),
                .eoi_i      (bank_eoi[b]),
                .eoi_line_i (eoi_line),
                .req_o      (bank_req[b]),
                .line_o     (bank_line[b]),
                .isr_o      (bank_isr[b])
            );
        end
    endgenerate

    // Sample the external chipset line as a level
    always_ff @(posedge clk) begin
        if (!rst_n) chip_q <= 1'b0;
        else        chip_q <= chip_irq_i;
    end

    // Route bank requests onto their master inputs
    always_comb begin
        m_req    = '0;
        m_req[0] = chip_q;
        for (int i = 0; i < NBANK; i++) m_req[bank_to_master(i)] = bank_req[i];
    end

    casc_irq_master u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (m_req),
        .mask_i     (mstr_mask),
        .grant_i    (grant_ok),
        .eoi_i      (mstr_eoi),
        .eoi_line_i (eoi_line),
        .win_o      (m_win),
        .idx_o      (m_idx),
        .isr_o      (m_isr)
    );

    // Map the winning master input back to its bank
    always_comb begin
        hit      = 1'b0;
        win_bank = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (m_idx == bank_to_master(i)) begin
                hit      = 1'b1;
                win_bank = BW'(i);
            end
        end
    end

    // Grant steering and output formation
    assign grant_ok = ack_i && m_win;
    always_comb begin
        for (int i = 0; i < NBANK; i++)
            bank_gnt[i] = grant_ok && hit && (win_bank == BW'(i));
    end

    assign irq_o = m_win;
    assign ext_o = m_win && (m_idx == '0);
    assign vec_o = (m_win && hit) ? {win_bank, bank_line[win_bank]} : '0;
endmodule

// File: rtl/casc_irq_chk.sv
// Assertion checker bound to the controller top; observes ports and cascade state.
module casc_irq_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              wr_en_i,
    input logic [3:0]        wr_addr_i,
    input logic [7:0]        wr_data_i,
    input logic              irq_o,
    input logic              ext_o,
    input logic [4:0]        vec_o,
    input logic [7:0]        m_isr,
    input logic [3:0][7:0]   bank_mask
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
    // R6
    ext_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_o |-> (irq_o && vec_o == 5'd0));
    // R4
    mask_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ext_o) |-> !bank_mask[vec_o[4:3]][vec_o[2:0]]);
    // R7
    grant_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (m_isr != 8'h00));
    // R9
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !(wr_en_i && wr_addr_i == 4'd12)) |=> $stable(m_isr));
    // R8
    non_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 4'd12 && wr_data_i[7:3] != 5'b11100 && !(ack_i && irq_o))
        |=> $stable(m_isr));
endmodule

bind casc_irq_ctrl casc_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o),
    .ext_o     (ext_o),
    .vec_o     (vec_o),
    .m_isr     (m_isr),
    .bank_mask (bank_mask)
);

// File: tb/sim_casc_irq_ctrl.sv
`timescale 1ns/100ps
module sim_casc_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        chip = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ack = 1'b0;
    logic        irq_o, ext_o;
    logic [4:0]  vec_o;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    casc_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .chip_irq_i(chip),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
        .irq_o(irq_o), .ext_o(ext_o), .vec_o(vec_o));

    // ---------------- behavioural reference model ----------------
    bit [7:0]  mb [4];
    bit [7:0]  mm, t0, t1, im;
    bit [7:0]  ib [4];
    bit [31:0] lat, smp;
    bit        chq;
    int        bank_in [4] = '{1, 3, 4, 5};

    function automatic bit is_level(int s);
        int e = s - 7;
        if (e >= 3 && e <= 7)   return t0[e-3];
        if (e >= 9 && e <= 11)  return t0[e-4];
        if (e == 12)            return t1[0];
        if (e == 14 || e == 15) return t1[e-13];
        return 0;
    endfunction

    function automatic void model_win(output bit w, output bit ex, output int vec,
                                      output int mi, output int bk);
        w = 0; ex = 0; vec = 0; mi = 0; bk = -1;
        for (int k = 0; k < 8 && !w; k++) begin
            if (im[k]) break;
            if (mm[k]) continue;
            if (k == 0) begin
                if (chq) begin w = 1; ex = 1; mi = 0; end
            end else begin
                for (int b = 0; b < 4; b++) begin
                    if (bank_in[b] != k) continue;
                    for (int l = 0; l < 8; l++) begin
                        int s = b*8 + l;
                        bit p = is_level(s) ? smp[s] : lat[s];
                        if (ib[b][l]) break;
                        if (p && !mb[b][l]) begin
                            w = 1; mi = k; bk = b; vec = s; break;
                        end
                    end
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin mb[b] = 8'hFF; ib[b] = 0; end
            mm = 0; t0 = 0; t1 = 0; im = 0; lat = 0; smp = 0; chq = 0;
        end else begin
            bit w, ex; int vec, mi, bk;
            bit [31:0] rise, nl;
            model_win(w, ex, vec, mi, bk);
            rise = src & ~smp;
            for (int s = 0; s < 32; s++) begin
                nl[s] = is_level(s) ? 1'b0 : (lat[s] | rise[s]);
                if (ack && w && !ex && s == vec && !is_level(s)) nl[s] = rise[s];
            end
            if (wr_en) begin
                if (wr_addr < 4) mb[wr_addr] = wr_data;
                else if (wr_addr == 4) mm = wr_data;
                else if (wr_addr == 5) t0 = wr_data;
                else if (wr_addr == 6) t1 = {5'b0, wr_data[2:0]};
                else if (wr_data[7:3] == 5'b11100) begin
                    if (wr_addr >= 8 && wr_addr <= 11) ib[wr_addr-8][wr_data[2:0]] = 0;
                    else if (wr_addr == 12) im[wr_data[2:0]] = 0;
                end
            end
            if (ack && w) begin
                im[mi] = 1;
                if (!ex) ib[bk][vec%8] = 1;
            end
            lat = nl; smp = src; chq = chip;
        end
    end

    // Compare every clock, away from the active edge (R5 general ordering)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit w, ex; int vec, mi, bk;
            model_win(w, ex, vec, mi, bk);
            vectors++;
            if (irq_o !== w || ext_o !== ex || (w && vec_o !== 5'(vec))) begin
                miscompares++;
                $display("FAIL R5 model: irq/ext/vec actual %b/%b/%0d expected %b/%b/%0d",
                         irq_o, ext_o, vec_o, w, ex, vec);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(); @(posedge clk); #1; endtask
    task automatic settle(int n); repeat (n) tick(); endtask
    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
    endtask
    task automatic pulse_ack(); ack = 1; tick(); ack = 0; endtask
    task automatic check(string tag, bit ei, bit ee, int ev);
        @(negedge clk);
        vectors++;
        if (irq_o !== ei || ext_o !== ee || (ei && vec_o !== 5'(ev))) begin
            miscompares++;
            $display("FAIL %s: irq/ext/vec actual %b/%b/%0d expected %b/%b/%0d",
                     tag, irq_o, ext_o, vec_o, ei, ee, ev);
        end
    endtask
    task automatic report();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        settle(3);
        rst_n = 1;
        check("R1 reset idle", 0, 0, 0);
        src[0] = 1; settle(3);
        check("R1 bank masks reset closed", 0, 0, 0);
        wr(0, 8'h00); settle(2);
        check("R4 masked edge kept", 1, 0, 0);
        src[0] = 0; settle(2);
        check("R2 edge latch holds", 1, 0, 0);
        pulse_ack(); settle(1);
        check("R2 grant clears latch", 0, 0, 0);
        src[1] = 1; settle(2);
        check("R7 lower line blocked", 0, 0, 0);
        wr(8, 8'hE0); settle(2);
        check("R8 bank EOI alone", 0, 0, 0);
        wr(12, 8'h61); settle(2);
        check("R8 non-EOI byte ignored", 0, 0, 0);
        wr(12, 8'hE1); settle(2);
        check("R8 both EOIs", 1, 0, 1);
        pulse_ack(); wr(8, 8'hE1); wr(12, 8'hE1); src[1] = 0; settle(2);
        check("R2 served edge gone", 0, 0, 0);
        // priority across the cascade
        wr(1, 8'h00); wr(3, 8'h00);
        src[25] = 1; src[9] = 1; src[14] = 1; settle(2);
        check("R5 bank1 line1 first", 1, 0, 9);
        pulse_ack(); settle(1);
        check("R7 in-service blocks lower", 0, 0, 0);
        chip = 1; settle(2);
        check("R6 external preempts", 1, 1, 0);
        chip = 0; settle(2);
        check("R6 external level drops", 0, 0, 0);
        wr(9, 8'hE1); wr(12, 8'hE3); settle(2);
        check("R5 bank1 line6 next", 1, 0, 14);
        pulse_ack(); wr(9, 8'hE6); wr(12, 8'hE3); settle(2);
        check("R5 bank3 on master input 5", 1, 0, 25);
        pulse_ack(); wr(11, 8'hE1); wr(12, 8'hE5);
        src = '0; settle(2);
        check("R5 all served", 0, 0, 0);
        // stray acknowledge
        pulse_ack(); settle(1);
        src[2] = 1; settle(2);
        check("R9 stray ack harmless", 1, 0, 2);
        pulse_ack(); wr(8, 8'hE2); wr(12, 8'hE1); src[2] = 0; settle(2);
        // level mode
        wr(5, 8'h01); src[10] = 1; settle(2);
        check("R3 level src10 high", 1, 0, 10);
        src[10] = 0; settle(2);
        check("R3 level src10 low", 0, 0, 0);
        wr(6, 8'h02); wr(2, 8'h00); src[21] = 1; settle(2);
        check("R3 level src21 high", 1, 0, 21);
        src[21] = 0; settle(2);
        check("R3 level src21 low", 0, 0, 0);
        src[13] = 1; settle(1); src[13] = 0; settle(2);
        check("R3 src13 stays edge", 1, 0, 13);
        pulse_ack(); wr(9, 8'hE5); wr(12, 8'hE3); settle(2);
        // master mask
        wr(4, 8'h08); src[9] = 1; settle(2);
        check("R4 master mask", 0, 0, 0);
        wr(4, 8'h00); settle(2);
        check("R4 master unmask", 1, 0, 9);
        pulse_ack(); wr(9, 8'hE1); wr(12, 8'hE3); src[9] = 0; settle(2);
        // latency
        src[4] = 1;
        check("R10 not before sample", 0, 0, 0);
        check("R10 one stage", 1, 0, 4);
        pulse_ack(); wr(8, 8'hE4); wr(12, 8'hE1); src[4] = 0; settle(2);
        // randomized phase, model compared each cycle
        for (int n = 0; n < 6000; n++) begin
            src  = src ^ ($urandom_range(0, 3) == 0 ? (32'h1 << $urandom_range(0, 31)) : 32'h0);
            chip = ($urandom_range(0, 15) == 0) ? ~chip : chip;
            ack  = ($urandom_range(0, 5) == 0);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_addr = 4'($urandom_range(0, 15));
            wr_data = ($urandom_range(0, 1) == 0) ? {5'b11100, 3'($urandom_range(0, 7))}
                                                  : 8'($urandom_range(0, 255));
            if (wr_addr < 5 && $urandom_range(0, 1) == 0) wr_data = 8'h00;
            tick();
        end
        ack = 0; wr_en = 0;
        settle(2);
        report();
    end
endmodule